// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor that completes one instruction per clock. Each instruction is fetched, decoded and executed, and its result is committed, within the same cycle. The core supports five register-to-register operations (add, subtract, and, or, signed set-less-than), plus or-with-immediate, word load, word store, branch-on-equal and an absolute jump. Instruction memory and data memory are word arrays inside the core. The testbench fills them before it releases reset.

The datapath has four parts: a program counter with next-address selection, a register file with two read ports and one write port, an immediate extender, and an ALU with a zero flag. A main decoder reads the opcode and sets the datapath selects. A local decoder reads the function field of register-format instructions. Each cycle the core also drives a set of commit outputs: the current PC, the register write it performs, and the store it performs. The surrounding system can follow execution through these outputs.

Top module: `sc_core`

## Requirements
- R1: A synchronous reset sets the PC to 0 and clears every register to 0.
- R2: When opcode 0x00 has function 0x20, 0x22, 0x24 or 0x25, the core writes register rd (bits 15:11) with rs+rt, rs−rt, rs&rt or rs|rt. The rs field is bits 25:21 and the rt field is bits 20:16.
- R3: Opcode 0x00 with function 0x2A writes 1 to rd when rs is less than rt as signed values, and writes 0 otherwise.
- R4: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits 15:0) into rt.
- R5: Opcode 0x23 writes rt with the data word at rs + sign-extended immediate. Data and instruction addresses select a word by byte-address bits 7:2, so addresses wrap modulo the 64-word depth.
- R6: Opcode 0x2B stores rt to the data word at rs + sign-extended immediate. It reports st_en_o=1 with the address and data, and it writes no register.
- R7: Opcode 0x04 takes the branch when rs equals rt. A taken branch moves the PC to PC+4+(sign-extended immediate<<2); otherwise the PC moves to PC+4.
- R8: Opcode 0x02 loads the PC with {(PC+4)[31:28], instruction[25:0], 2'b00}.
- R9: Every instruction other than a branch or a jump advances the PC by 4.
- R10: Register 0 always reads as 0. A write aimed at register 0 is dropped and reports wr_en_o=0.
- R11: An unsupported opcode, or opcode 0x00 with an unsupported function, writes nothing and advances the PC by 4.
- R12: A register or memory write takes effect at the rising edge, so the next instruction reads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| wr_en_o | output | 1 | A register is written at the next edge |
| wr_idx_o | output | 5 | Index of the register written |
| wr_data_o | output | 32 | Value written to the register |
| st_en_o | output | 1 | A data word is stored at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Data stored |

## Verification
The bench targets signed comparison between a negative and a positive operand, where a design that compares unsigned values would return the inverted result. It also checks that or-immediate does not sign-extend: with the immediate 0xFFFF, a design that extends it the wrong way would write 0xFFFFFFFF instead of 0x0000FFFF. Negative load and store offsets exercise address wraparound. A write to register 0 followed by a read of it would expose a register file that keeps the value. Branch offsets are both taken and not taken, and jumps use random targets, so a wrong shift or a wrong upper-bit splice shows up as a PC mismatch on the next instruction.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    b_imm;
        logic    zero_ext;
        logic    mem_to_reg;
        logic    mem_we;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);
    logic    rtype;
    alu_op_e main_alu;
    alu_op_e local_alu;
    logic    funct_ok;

    // main decode: opcode -> datapath selects
    always_comb begin
        ctrl_o   = '0;
        rtype    = 1'b0;
        main_alu = ALU_ADD;
        unique case (op_i)
            OP_RTYPE: begin
                rtype         = 1'b1;
                ctrl_o.dst_rd = 1'b1;
                ctrl_o.reg_we = funct_ok;
            end
            OP_ORI: begin
                ctrl_o.reg_we   = 1'b1;
                ctrl_o.b_imm    = 1'b1;
                ctrl_o.zero_ext = 1'b1;
                main_alu        = ALU_OR;
            end
            OP_LW: begin
                ctrl_o.reg_we     = 1'b1;
                ctrl_o.b_imm      = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctrl_o.b_imm  = 1'b1;
                ctrl_o.mem_we = 1'b1;
            end
            OP_BEQ: begin
                ctrl_o.branch = 1'b1;
                main_alu      = ALU_SUB;
            end
            OP_J:    ctrl_o.jump = 1'b1;
            default: ;
        endcase
        ctrl_o.alu_op = rtype ? local_alu : main_alu;
    end

    // local decode: function field for register-format instructions
    always_comb begin
        funct_ok  = 1'b1;
        local_alu = ALU_ADD;
        unique case (funct_i)
            FN_ADD:  local_alu = ALU_ADD;
            FN_SUB:  local_alu = ALU_SUB;
            FN_AND:  local_alu = ALU_AND;
            FN_OR:   local_alu = ALU_OR;
            FN_SLT:  local_alu = ALU_SLT;
            default: funct_ok  = 1'b0;   // R11: unsupported function writes nothing
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_op_e      op_i,
    output logic [W-1:0] y_o,
    output logic         zero_o
);
    always_comb begin
        unique case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
            default: y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    input  logic [AW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_a_o,
    output logic [W-1:0]  rdata_b_o
);
    // entry 0 has no storage: it is hard-wired to zero
    logic [W-1:0] regs_q [1:NREG-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
        end else if (we_i && (waddr_i != '0)) begin
            regs_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
    assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         we_i,
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o
);
    logic [W-1:0] mem_q [DEPTH];
    logic [IW-1:0] idx;
    logic unused_addr_bits;

    // word select from byte address, wrapping modulo DEPTH
    assign idx              = addr_i[IW+1:2];
    assign unused_addr_bits = ^{addr_i[W-1:IW+2], addr_i[1:0]};

    always_ff @(posedge clk) begin
        if (we_i) mem_q[idx] <= wdata_i;
    end

    assign rdata_o = mem_q[idx];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int NREG       = 32,
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    localparam int RAW       = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] pc_o,
    output logic            wr_en_o,
    output logic [RAW-1:0]  wr_idx_o,
    output logic [XLEN-1:0] wr_data_o,
    output logic            st_en_o,
    output logic [XLEN-1:0] st_addr_o,
    output logic [XLEN-1:0] st_data_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [XLEN-1:0] instr_w;
    logic [5:0]      op_w, funct_w;
    logic [RAW-1:0]  rs_w, rt_w, rd_w, dst_w;
    logic [15:0]     imm_w;
    logic            unused_shamt;
    ctrl_t           ctrl_w;
    logic [XLEN-1:0] ext_w, ra_w, rb_w, alu_b_w, alu_y_w, ld_w, wb_w, pc4_w;
    logic            zero_w;

    sc_mem #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
        .clk    (clk),
        .we_i   (1'b0),
        .addr_i (state_q.pc),
        .wdata_i('0),
        .rdata_o(instr_w)
    );

    assign op_w         = instr_w[31:26];
    assign rs_w         = instr_w[25:21];
    assign rt_w         = instr_w[20:16];
    assign rd_w         = instr_w[15:11];
    assign funct_w      = instr_w[5:0];
    assign imm_w        = instr_w[15:0];
    assign unused_shamt = ^instr_w[10:6];

    sc_ctrl u_ctrl (
        .op_i   (op_w),
        .funct_i(funct_w),
        .ctrl_o (ctrl_w)
    );

    sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .we_i     (ctrl_w.reg_we),
        .waddr_i  (dst_w),
        .wdata_i  (wb_w),
        .raddr_a_i(rs_w),
        .raddr_b_i(rt_w),
        .rdata_a_o(ra_w),
        .rdata_b_o(rb_w)
    );

    assign ext_w   = ctrl_w.zero_ext ? {{(XLEN-16){1'b0}}, imm_w}
                                     : {{(XLEN-16){imm_w[15]}}, imm_w};
    assign alu_b_w = ctrl_w.b_imm ? ext_w : rb_w;

    sc_alu #(.W(XLEN)) u_alu (
        .a_i   (ra_w),
        .b_i   (alu_b_w),
        .op_i  (ctrl_w.alu_op),
        .y_o   (alu_y_w),
        .zero_o(zero_w)
    );

    sc_mem #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
        .clk    (clk),
        .we_i   (ctrl_w.mem_we),
        .addr_i (alu_y_w),
        .wdata_i(rb_w),
        .rdata_o(ld_w)
    );

    assign wb_w  = ctrl_w.mem_to_reg ? ld_w : alu_y_w;
    assign dst_w = ctrl_w.dst_rd ? rd_w : rt_w;
    assign pc4_w = state_q.pc + 32'd4;

    always_comb begin
        state_d = state_q;
        if (ctrl_w.jump)
            state_d.pc = {pc4_w[31:28], instr_w[25:0], 2'b00};
        else if (ctrl_w.branch && zero_w)
            state_d.pc = pc4_w + {ext_w[XLEN-3:0], 2'b00};
        else
            state_d.pc = pc4_w;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign pc_o      = state_q.pc;
    assign wr_en_o   = ctrl_w.reg_we && (dst_w != '0);
    assign wr_idx_o  = dst_w;
    assign wr_data_o = wb_w;
    assign st_en_o   = ctrl_w.mem_we;
    assign st_addr_o = alu_y_w;
    assign st_data_o = rb_w;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic        wr_en_o,
    input logic [4:0]  wr_idx_o,
    input logic        st_en_o,
    input logic [31:0] instr
);
    logic [31:0] pc4_w;
    assign pc4_w = pc_o + 32'd4;

    p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_o == 32'd0));

    p_store_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        st_en_o |-> !wr_en_o);

    p_zero_reg_never_written_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_idx_o != 5'd0));

    p_sequential_pc_r9: assert property (@(posedge clk) disable iff (rst)
        ((instr[31:26] != 6'h04) && (instr[31:26] != 6'h02))
        |=> (pc_o == $past(pc4_w)));

    p_jump_target_r8: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == 6'h02)
        |=> (pc_o == {$past(pc4_w[31:28]), $past(instr[25:0]), 2'b00}));

    p_word_aligned_pc_r7: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc_o    (pc_o),
    .wr_en_o (wr_en_o),
    .wr_idx_o(wr_idx_o),
    .st_en_o (st_en_o),
    .instr   (instr_w)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
module sc_core_tb_top;
    localparam int DEPTH = 64;
    localparam int IW    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o, wr_data_o, st_addr_o, st_data_o;
    logic        wr_en_o, st_en_o;
    logic [4:0]  wr_idx_o;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_reg  [32];
    logic [31:0] m_dmem [DEPTH];
    logic [31:0] m_imem [DEPTH];
    logic [31:0] m_pc;
    string       pc_tag;

    always #2.5 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst(rst), .pc_o(pc_o),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h pc=%h", tag, what, act, exp, m_pc);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] rand_instr();
        int k  = $urandom_range(0, 12);
        int rs = $urandom_range(0, 7);
        int rt = $urandom_range(0, 7);
        int rd = $urandom_range(0, 7);
        logic [15:0] imm = 16'($urandom);
        logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        case (k)
            0, 1, 2:  return enc_r(fns[$urandom_range(0, 4)], rd, rs, rt);
            3:        return enc_r(6'h2A, rd, rs, rt);
            4, 5:     return enc_i(6'h0D, rt, rs, imm);
            6:        return enc_i(6'h23, rt, rs, imm);
            7:        return enc_i(6'h2B, rt, rs, imm);
            8:        return enc_i(6'h04, rt, rs, 16'($signed($urandom_range(0, 15)) - 8));
            9:        return {6'h02, 26'($urandom_range(0, DEPTH - 1))};
            10:       return enc_r(6'h27, rd, rs, rt);          // unsupported function
            11:       return enc_i(6'h08, rt, rs, imm);         // unsupported opcode
            default:  return enc_i(6'h0D, rt, 0, imm);
        endcase
    endfunction

    task automatic load_program(input bit directed);
        for (int i = 0; i < DEPTH; i++) begin
            m_imem[i] = rand_instr();
            m_dmem[i] = $urandom;
        end
        if (directed) begin
            m_imem[0]  = enc_i(6'h0D, 1, 0, 16'hFFFF);      // r1 = 0000FFFF
            m_imem[1]  = enc_r(6'h22, 2, 0, 1);             // r2 = -65535
            m_imem[2]  = enc_r(6'h2A, 3, 2, 1);             // signed: 1
            m_imem[3]  = enc_r(6'h2A, 3, 1, 2);             // signed: 0
            m_imem[4]  = enc_r(6'h20, 0, 1, 1);             // write to r0 dropped
            m_imem[5]  = enc_r(6'h20, 4, 0, 1);             // r0 reads 0
            m_imem[6]  = enc_i(6'h2B, 1, 0, 16'hFFFC);      // store at word 63
            m_imem[7]  = enc_i(6'h23, 5, 0, 16'hFFFC);      // load it back
            m_imem[8]  = enc_i(6'h04, 1, 5, 16'h0001);      // taken, skip 9
            m_imem[9]  = enc_i(6'h0D, 6, 0, 16'h0001);
            m_imem[10] = enc_i(6'h04, 0, 5, 16'h0005);      // not taken
            m_imem[11] = enc_r(6'h24, 7, 1, 2);
            m_imem[12] = {6'h02, 26'd20};
            m_imem[20] = enc_i(6'h0D, 6, 0, 16'h8000);      // zero-extended
            m_imem[21] = enc_i(6'h04, 0, 0, 16'hFFEA);      // back to word 0
        end
        for (int i = 0; i < DEPTH; i++) begin
            dut_i.u_imem.mem_q[i] = m_imem[i];
            dut_i.u_dmem.mem_q[i] = m_dmem[i];
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = 32'd0;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        chk("R1", "pc after reset", pc_o, 32'd0);
        chk("R1", "no store after reset", {31'd0, st_en_o}, {31'd0, m_imem[0][31:26] == 6'h2B});
        pc_tag = "R1";
    endtask

    task automatic step();
        logic [31:0] ins = m_imem[m_pc[IW+1:2]];
        logic [5:0]  op  = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        int          rs  = ins[25:21];
        int          rt  = ins[20:16];
        int          rd  = ins[15:11];
        logic [31:0] a   = m_reg[rs];
        logic [31:0] b   = m_reg[rt];
        logic [31:0] sx  = {{16{ins[15]}}, ins[15:0]};
        logic [31:0] zx  = {16'd0, ins[15:0]};
        logic [31:0] pc4 = m_pc + 32'd4;
        logic [31:0] npc = pc4;
        logic [31:0] res = 32'd0;
        logic [31:0] ad  = a + sx;
        bit          hw  = 1'b0;
        bit          st  = 1'b0;
        int          dst = rt;
        string       tag = "R11";
        string       ntag = "R9";

        chk(pc_tag, "pc", pc_o, m_pc);
        case (op)
            6'h00: begin
                dst = rd; hw = 1'b1; tag = "R2";
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
                    default: begin hw = 1'b0; tag = "R11"; end
                endcase
            end
            6'h0D: begin hw = 1'b1; res = a | zx; tag = "R4"; end
            6'h23: begin hw = 1'b1; res = m_dmem[ad[IW+1:2]]; tag = "R5"; end
            6'h2B: begin st = 1'b1; tag = "R6"; end
            6'h04: begin tag = "R7"; ntag = "R7"; if (a == b) npc = pc4 + {sx[29:0], 2'b00}; end
            6'h02: begin tag = "R8"; ntag = "R8"; npc = {pc4[31:28], ins[25:0], 2'b00}; end
            default: ;
        endcase
        if (hw && dst == 0) tag = "R10";

        chk(tag, "wr_en", {31'd0, wr_en_o}, {31'd0, hw && dst != 0});
        if (hw && dst != 0) begin
            chk(tag, "wr_idx", {27'd0, wr_idx_o}, 32'(dst));
            chk(tag, "wr_data (R12 visibility)", wr_data_o, res);
        end
        chk(st ? "R6" : tag, "st_en", {31'd0, st_en_o}, {31'd0, st});
        if (st) begin
            chk("R6", "st_addr", st_addr_o, ad);
            chk("R6", "st_data", st_data_o, b);
        end

        if (hw && dst != 0) m_reg[dst] = res;
        if (st) m_dmem[ad[IW+1:2]] = b;
        m_pc   = npc;
        pc_tag = ntag;
        @(negedge clk);
    endtask

    initial begin
        #1ms;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5C1E_0A7B));
        for (int p = 0; p < 12; p++) begin
            load_program(p == 0);
            do_reset();
            for (int c = 0; c < ((p == 0) ? 80 : 400); c++) step();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule